// File: doc/BRIEF.md
# Dead-Time PWM Timer Generator

This block is a pulse-width timer built around a single up-counter. It drives a pair of gate outputs for a half-bridge stage. The two gates do not switch together. After a programmable dead time, the secondary gate follows the primary gate on. At the end of the period the secondary gate drops first, and the primary gate drops one dead time later. A third output, a strobe, goes active partway through each cycle so that it can start a converter sample. A separate route enable copies the strobe to a pin output.

Software sets the following through plain input ports:
- two compare levels;
- the period value;
- a 5-bit dead time;
- one polarity bit and one enable per gate.

At the period match the block raises a pending flag, which software clears, and an interrupt request when that is enabled. A fault input has two modes, selected by a mode bit. In one mode it silences both gates for the rest of the current cycle. In the other it stops the timer until software drops the run enable.

A controller sequences the cycle through six named states:
- `ST_IDLE`: stopped, counter held at zero.
- `ST_LEAD`: counting, both gates resting.
- `ST_GAP_ON`: primary gate on, dead time running.
- `ST_BOTH`: both gates on.
- `ST_GAP_OFF`: secondary gate off, dead time running before the primary gate drops.
- `ST_PAD`: dead time running with both gates resting, used when the period ends before compare A is seen.

The state transitions are:
- `ST_IDLE` to `ST_LEAD` on start.
- `ST_LEAD` to `ST_GAP_ON` on an A match.
- `ST_GAP_ON` to `ST_BOTH` when the dead time expires.
- `ST_BOTH` to `ST_GAP_OFF` on a period match.
- `ST_GAP_OFF` or `ST_PAD` to `ST_LEAD` when the dead time expires. This is the wrap.
- From any running state to `ST_IDLE` on stop.

With a dead time of zero, the gap states are skipped and the paired edges fall in the same clock.

Top module: `dtpwm_timer`

## Requirements
- R1: While reset is applied, and directly after it, each gate output equals its polarity bit (resting), and strobe, strobe_pin, pend and irq are all 0.
- R2: The cycle starts with the counter at 0. The counter is compared with cmp_a, and the primary gate becomes active in the clock after the match. It stays active for period + dead - cmp_a clocks per cycle.
- R3: The secondary gate turns active dead clocks after the primary gate and turns off in the clock after the counter matches period. The primary gate turns off dead clocks after that, so the secondary gate is active for period - cmp_a - dead clocks. With dead = 0 the paired edges switch in the same clock.
- R4: One cycle lasts period + dead + 1 clocks. Each new cycle starts with the counter at 0 and the strobe resting, and it repeats the same gate timing.
- R5: A polarity bit of 0 makes that gate active-high, and a bit of 1 makes it active-low (drive = active XOR polarity).
- R6: A gate whose enable is 0 holds its polarity level for the whole cycle, while the counter, strobe and pending flag keep running.
- R7: The strobe rests at cycle start and goes active in the clock after the counter matches cmp_b, staying active until the wrap. strobe_pin equals strobe when strobe_route is 1 and is 0 otherwise.
- R8: pend is set in the clock after the counter matches period and stays set until pend_clr is sampled high. A set in the same clock as a clear wins. irq is pend AND irq_en.
- R9: With fault_halt = 0, a sampled fault_in forces both gates to rest from the next clock until the end of the current cycle. The counter, strobe and pend carry on, and the next cycle runs normally.
- R10: With fault_halt = 1, a sampled fault_in stops the timer from the next clock: gates rest, strobe is 0 and pend is not set. The timer stays stopped while run_en remains high. It restarts from count 0 once run_en has been sampled low and then high.
- R11: Sampling run_en low stops the timer from the next clock, with gates resting, strobe 0 and the counter cleared.
- R12: The dead time is a 5-bit count of clocks, from 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Timer run enable |
| cmp_a | input | W | Count at which the primary gate turns on |
| cmp_b | input | W | Count at which the strobe turns on |
| period | input | W | Count at which the secondary gate turns off |
| dead | input | DW (5) | Dead time in clocks |
| pol_p | input | 1 | Primary gate polarity (1 = active-low) |
| pol_s | input | 1 | Secondary gate polarity (1 = active-low) |
| en_p | input | 1 | Primary gate enable |
| en_s | input | 1 | Secondary gate enable |
| strobe_route | input | 1 | Copies strobe onto strobe_pin |
| irq_en | input | 1 | Interrupt enable |
| pend_clr | input | 1 | Clears the pending flag |
| fault_in | input | 1 | Fault request |
| fault_halt | input | 1 | Fault mode: 1 stops the timer, 0 silences the current cycle |
| drv_p | output | 1 | Primary gate drive |
| drv_s | output | 1 | Secondary gate drive |
| strobe | output | 1 | Internal strobe, always generated |
| strobe_pin | output | 1 | Routed strobe |
| pend | output | 1 | Period pending flag |
| irq | output | 1 | Interrupt request |

## Verification
The clocked properties check every cycle that the gate ordering holds: with a non-zero dead time, the secondary gate only rises while the primary gate is already active, and it is already off when the primary gate drops. They also check that any fault leaves both gates resting one clock later, that the strobe only rises after a cmp_b match, that pend holds until cleared, and that a disabled gate sits at its polarity level. Only the bench's scenarios can show the exact edge clocks and active widths for each configuration, the cycle length including the dead-time extension, the clock in which pend rises, and the difference between the two fault modes over a whole cycle. They also cover restart after a halt and the effect of dropping run_en.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;

    // Controller phases of one PWM cycle
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LEAD    = 3'd1,
        ST_GAP_ON  = 3'd2,
        ST_BOTH    = 3'd3,
        ST_GAP_OFF = 3'd4,
        ST_PAD     = 3'd5
    } phase_e;

    localparam int unsigned GATES = 2;

endpackage

// File: rtl/dtpwm_count.sv
module dtpwm_count #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         hit_a,
    output logic         hit_b,
    output logic         hit_p
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + ONE;
        end
    end

    always_comb begin
        hit_a = (cnt == cmp_a);
        hit_b = (cnt == cmp_b);
        hit_p = (cnt == period);
    end

endmodule

// File: rtl/dtpwm_dead.sv
module dtpwm_dead #(
    parameter int unsigned DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] dead,
    output logic          done
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= dead;
        end else if (left_q != '0) begin
            left_q <= left_q - ONE;
        end
    end

    // Last clock of the gap; a zero count also releases so a gap never hangs
    assign done = (left_q <= ONE);

endmodule

// File: rtl/dtpwm_fsm.sv
module dtpwm_fsm
    import dtpwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  logic   halted,
    input  logic   trip,
    input  logic   hit_a,
    input  logic   hit_p,
    input  logic   dt_done,
    input  logic   dead_zero,
    output phase_e state,
    output logic   wrap,
    output logic   stop,
    output logic   dt_load,
    output logic   counting,
    output logic   idle,
    output logic   ph_p,
    output logic   ph_s
);

    phase_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Next state and transition strobes
    always_comb begin
        state_d = state;
        wrap    = 1'b0;
        stop    = 1'b0;
        dt_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (run && !halted && !trip) begin
                    state_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (hit_p) begin
                    if (dead_zero) begin
                        state_d = ST_LEAD;
                        wrap    = 1'b1;
                    end else begin
                        state_d = ST_PAD;
                        dt_load = 1'b1;
                    end
                end else if (hit_a) begin
                    if (dead_zero) begin
                        state_d = ST_BOTH;
                    end else begin
                        state_d = ST_GAP_ON;
                        dt_load = 1'b1;
                    end
                end
            end
            ST_GAP_ON: begin
                if (hit_p) begin
                    if (dead_zero) begin
                        state_d = ST_LEAD;
                        wrap    = 1'b1;
                    end else begin
                        state_d = ST_GAP_OFF;
                        dt_load = 1'b1;
                    end
                end else if (dt_done) begin
                    state_d = ST_BOTH;
                end
            end
            ST_BOTH: begin
                if (hit_p) begin
                    if (dead_zero) begin
                        state_d = ST_LEAD;
                        wrap    = 1'b1;
                    end else begin
                        state_d = ST_GAP_OFF;
                        dt_load = 1'b1;
                    end
                end
            end
            ST_GAP_OFF, ST_PAD: begin
                if (dt_done) begin
                    state_d = ST_LEAD;
                    wrap    = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase

        // Stop request overrides any running transition
        if (state != ST_IDLE && (!run || trip)) begin
            state_d = ST_IDLE;
            wrap    = 1'b0;
            dt_load = 1'b0;
            stop    = 1'b1;
        end
    end

    // Phase decode
    always_comb begin
        counting = 1'b0;
        idle     = 1'b0;
        ph_p     = 1'b0;
        ph_s     = 1'b0;
        unique case (state)
            ST_IDLE:    idle = 1'b1;
            ST_LEAD:    counting = 1'b1;
            ST_GAP_ON: begin
                counting = 1'b1;
                ph_p     = 1'b1;
            end
            ST_BOTH: begin
                counting = 1'b1;
                ph_p     = 1'b1;
                ph_s     = 1'b1;
            end
            ST_GAP_OFF: ph_p = 1'b1;
            ST_PAD:     ph_p = 1'b0;
            default:    idle = 1'b1;
        endcase
    end

endmodule

// File: rtl/dtpwm_flags.sv
module dtpwm_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fault_in,
    input  logic fault_halt,
    input  logic hit_b,
    input  logic hit_p,
    input  logic counting,
    input  logic idle,
    input  logic wrap,
    input  logic stop,
    input  logic pend_clr,
    output logic strobe,
    output logic pend,
    output logic kill,
    output logic halted
);

    logic trip_cycle;
    logic trip_stop;

    assign trip_cycle = fault_in && !fault_halt;
    assign trip_stop  = fault_in && fault_halt;

    // Strobe: rests at cycle start, on after the B match
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe <= 1'b0;
        end else if (idle || wrap || stop) begin
            strobe <= 1'b0;
        end else if (counting && hit_b) begin
            strobe <= 1'b1;
        end
    end

    // Pending flag: a new set outranks a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (counting && hit_p) begin
            pend <= 1'b1;
        end else if (pend_clr) begin
            pend <= 1'b0;
        end
    end

    // Per-cycle gate silencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kill <= 1'b0;
        end else if (wrap || stop || idle) begin
            kill <= 1'b0;
        end else if (trip_cycle) begin
            kill <= 1'b1;
        end
    end

    // Whole-timer stop, released by dropping run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halted <= 1'b0;
        end else if (trip_stop) begin
            halted <= 1'b1;
        end else if (!run) begin
            halted <= 1'b0;
        end
    end

endmodule

// File: rtl/dtpwm_timer.sv
module dtpwm_timer
    import dtpwm_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [W-1:0]  cmp_a,
    input  logic [W-1:0]  cmp_b,
    input  logic [W-1:0]  period,
    input  logic [DW-1:0] dead,
    input  logic          pol_p,
    input  logic          pol_s,
    input  logic          en_p,
    input  logic          en_s,
    input  logic          strobe_route,
    input  logic          irq_en,
    input  logic          pend_clr,
    input  logic          fault_in,
    input  logic          fault_halt,
    output logic          drv_p,
    output logic          drv_s,
    output logic          strobe,
    output logic          strobe_pin,
    output logic          pend,
    output logic          irq
);

    logic [W-1:0] cnt_q;
    logic         hit_a, hit_b, hit_p;
    logic         dt_done, dt_load;
    logic         wrap, stop, counting, idle;
    logic         ph_p, ph_s;
    logic         kill, halted;
    phase_e       state;

    logic [GATES-1:0] phase_v;
    logic [GATES-1:0] pol_v;
    logic [GATES-1:0] en_v;
    logic [GATES-1:0] drv_v;

    dtpwm_count #(.W(W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wrap || stop || idle),
        .inc    (counting),
        .cmp_a  (cmp_a),
        .cmp_b  (cmp_b),
        .period (period),
        .cnt    (cnt_q),
        .hit_a  (hit_a),
        .hit_b  (hit_b),
        .hit_p  (hit_p)
    );

    dtpwm_dead #(.DW(DW)) u_dead (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dt_load),
        .dead  (dead),
        .done  (dt_done)
    );

    dtpwm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_en),
        .halted    (halted),
        .trip      (fault_in && fault_halt),
        .hit_a     (hit_a),
        .hit_p     (hit_p),
        .dt_done   (dt_done),
        .dead_zero (dead == '0),
        .state     (state),
        .wrap      (wrap),
        .stop      (stop),
        .dt_load   (dt_load),
        .counting  (counting),
        .idle      (idle),
        .ph_p      (ph_p),
        .ph_s      (ph_s)
    );

    dtpwm_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_en),
        .fault_in   (fault_in),
        .fault_halt (fault_halt),
        .hit_b      (hit_b),
        .hit_p      (hit_p),
        .counting   (counting),
        .idle       (idle),
        .wrap       (wrap),
        .stop       (stop),
        .pend_clr   (pend_clr),
        .strobe     (strobe),
        .pend       (pend),
        .kill       (kill),
        .halted     (halted)
    );

    assign phase_v = {ph_s, ph_p};
    assign pol_v   = {pol_s, pol_p};
    assign en_v    = {en_s, en_p};

    // One output stage per gate: gate by enable and fault, then apply polarity
    for (genvar g = 0; g < GATES; g++) begin : g_gate
        always_comb begin
            drv_v[g] = (phase_v[g] && en_v[g] && !kill) ^ pol_v[g];
        end
    end

    assign drv_p      = drv_v[0];
    assign drv_s      = drv_v[1];
    assign strobe_pin = strobe && strobe_route;
    assign irq        = pend && irq_en;

endmodule

// File: rtl/dtpwm_timer_chk.sv
module dtpwm_timer_chk #(
    parameter int unsigned W  = 8,
    parameter int unsigned DW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic          fault_in,
    input logic [DW-1:0] dead,
    input logic          pend,
    input logic          pend_clr,
    input logic          strobe,
    input logic [W-1:0]  cmp_b,
    input logic [W-1:0]  cnt,
    input logic          ph_p,
    input logic          ph_s,
    input logic          drv_p,
    input logic          drv_s,
    input logic          pol_p,
    input logic          pol_s,
    input logic          en_p
);

    // R9 and R10: any fault leaves both gates resting one clock later
    assert_fault_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> ((drv_p == pol_p) && (drv_s == pol_s)));

    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !pend_clr) |=> pend);

    assert_strobe_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(cnt == cmp_b));

    assert_trail_on_after_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ph_s) && ($past(dead) != '0)) |-> $past(ph_p));

    assert_trail_off_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ph_p) && $past(run_en && !fault_in) && ($past(dead) != '0)) |-> !$past(ph_s));

    assert_disabled_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_p |-> (drv_p == pol_p));

endmodule

bind dtpwm_timer dtpwm_timer_chk #(.W(W), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .fault_in (fault_in),
    .dead     (dead),
    .pend     (pend),
    .pend_clr (pend_clr),
    .strobe   (strobe),
    .cmp_b    (cmp_b),
    .cnt      (cnt_q),
    .ph_p     (ph_p),
    .ph_s     (ph_s),
    .drv_p    (drv_p),
    .drv_s    (drv_s),
    .pol_p    (pol_p),
    .pol_s    (pol_s),
    .en_p     (en_p)
);

// File: tb/dtpwm_timer_bench.sv
module dtpwm_timer_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W  = 8;
    localparam int DW = 5;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] p;
        logic [4:0] d;
        logic       pp;
        logic       ps;
        logic       ep;
        logic       es;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'd2, 8'd5,  8'd10, 5'd3,  1'b0, 1'b0, 1'b1, 1'b1},
        '{8'd3, 8'd0,  8'd8,  5'd0,  1'b1, 1'b0, 1'b1, 1'b1},
        '{8'd1, 8'd7,  8'd12, 5'd5,  1'b1, 1'b1, 1'b1, 1'b1},
        '{8'd4, 8'd4,  8'd9,  5'd2,  1'b0, 1'b0, 1'b1, 1'b0},
        '{8'd0, 8'd20, 8'd40, 5'd31, 1'b0, 1'b1, 1'b1, 1'b1},
        '{8'd5, 8'd9,  8'd9,  5'd1,  1'b1, 1'b0, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [W-1:0]  cmp_a = '0, cmp_b = '0, period = '0;
    logic [DW-1:0] dead = '0;
    logic          pol_p = 1'b1, pol_s = 1'b0, en_p = 1'b1, en_s = 1'b1;
    logic          strobe_route = 1'b0, irq_en = 1'b0, pend_clr = 1'b0;
    logic          fault_in = 1'b0, fault_halt = 1'b0;
    logic          drv_p, drv_s, strobe, strobe_pin, pend, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dtpwm_timer #(.W(W), .DW(DW)) u_dtpwm_timer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .period(period), .dead(dead), .pol_p(pol_p), .pol_s(pol_s), .en_p(en_p),
        .en_s(en_s), .strobe_route(strobe_route), .irq_en(irq_en), .pend_clr(pend_clr),
        .fault_in(fault_in), .fault_halt(fault_halt), .drv_p(drv_p), .drv_s(drv_s),
        .strobe(strobe), .strobe_pin(strobe_pin), .pend(pend), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        cmp_a  = v.a;
        cmp_b  = v.b;
        period = v.p;
        dead   = v.d;
        pol_p  = v.pp;
        pol_s  = v.ps;
        en_p   = v.ep;
        en_s   = v.es;
    endtask

    task automatic stop_and_clear();
        @(negedge clk);
        run_en   = 1'b0;
        pend_clr = 1'b1;
        @(negedge clk);
        pend_clr = 1'b0;
    endtask

    task automatic start();
        @(negedge clk);
        run_en = 1'b1;
    endtask

    function automatic bit act_p();
        return drv_p ^ pol_p;
    endfunction

    function automatic bit act_s();
        return drv_s ^ pol_s;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(drv_p == 1'b1 && drv_s == 1'b0, "R1 gates rest in reset", {drv_p, drv_s}, 2);
        chk(!strobe && !strobe_pin && !pend && !irq, "R1 flags clear in reset",
            {strobe, strobe_pin, pend, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drv_p == 1'b1 && drv_s == 1'b0 && !pend, "R1 rest after reset", {drv_p, drv_s, pend}, 4);

        // Vector walk: R2 R3 R4 R5 R6 R7 R8 R12
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            int L, c1, c2, cs, prise, pinbad, e1, e2, es, lim;
            v = VEC[i];
            stop_and_clear();
            load(v);
            strobe_route = i[0];
            start();
            L = int'(v.p) + int'(v.d) + 1;
            lim = L + int'(v.a) + 1;
            c1 = 0; c2 = 0; cs = 0; prise = -1; pinbad = 0;
            for (int k = 0; k <= lim; k++) begin
                @(negedge clk);
                if (k < L) begin
                    c1 += int'(act_p());
                    c2 += int'(act_s());
                    cs += int'(strobe);
                end
                if (pend && prise < 0) prise = k;
                if (strobe_pin != (strobe && strobe_route)) pinbad++;
                if (k == L) begin
                    chk(!strobe, "R4 strobe rests at new cycle", int'(strobe), 0);
                end
                if (k == L + int'(v.a)) begin
                    chk(!act_p(), "R4 primary rests before A in next cycle", int'(act_p()), 0);
                end
                if (k == lim) begin
                    chk(act_p() == v.ep, "R4 primary repeats in next cycle", int'(act_p()), int'(v.ep));
                end
            end
            e1 = v.ep ? (int'(v.p) + int'(v.d) - int'(v.a)) : 0;
            e2 = v.es ? (int'(v.p) - int'(v.a) - int'(v.d)) : 0;
            es = int'(v.p) + int'(v.d) - int'(v.b);
            chk(c1 == e1, "R2 R5 R12 primary active clocks", c1, e1);
            chk(c2 == e2, "R3 R6 secondary active clocks", c2, e2);
            chk(cs == es, "R7 strobe active clocks", cs, es);
            chk(pinbad == 0, "R7 strobe_pin routing", pinbad, 0);
            chk(prise == int'(v.p) + 1, "R8 pend rise clock", prise, int'(v.p) + 1);
        end

        // R8: irq follows pend and enable; clear works
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R8 irq with pend and enable", int'(irq), 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq masked", int'(irq), 0);

        // R8: set wins over a held clear
        stop_and_clear();
        load(VEC[0]);
        pend_clr = 1'b1;
        start();
        for (int k = 0; k <= 12; k++) begin
            @(negedge clk);
            if (k == 11) chk(pend == 1'b1, "R8 set wins over clear", int'(pend), 1);
            if (k == 12) chk(pend == 1'b0, "R8 clear after set", int'(pend), 0);
        end
        pend_clr = 1'b0;

        // R9: fault silences the current cycle only
        stop_and_clear();
        load(VEC[0]);
        fault_halt = 1'b0;
        start();
        for (int k = 0; k <= 20; k++) begin
            @(negedge clk);
            if (k == 7) chk(act_s() == 1'b1, "R9 secondary on before fault", int'(act_s()), 1);
            if (k >= 8 && k <= 13)
                chk(!act_p() && !act_s(), "R9 gates rest after fault", {act_p(), act_s()}, 0);
            if (k == 9) chk(strobe == 1'b1, "R9 strobe continues", int'(strobe), 1);
            if (k == 11) chk(pend == 1'b1, "R9 pend still set", int'(pend), 1);
            if (k == 17) chk(act_p() == 1'b1, "R9 next cycle primary", int'(act_p()), 1);
            if (k == 20) chk(act_s() == 1'b1, "R9 next cycle secondary", int'(act_s()), 1);
            if (k == 7) fault_in = 1'b1;
            if (k == 8) fault_in = 1'b0;
        end

        // R10: fault stops the timer until run drops
        stop_and_clear();
        fault_halt = 1'b1;
        start();
        for (int k = 0; k <= 40; k++) begin
            @(negedge clk);
            if (k >= 6 && (act_p() || act_s() || strobe || pend))
                chk(1'b0, "R10 timer stopped", {act_p(), act_s(), strobe, pend}, 0);
            if (k == 40) chk(!act_p() && !pend, "R10 still stopped", {act_p(), pend}, 0);
            if (k == 5) fault_in = 1'b1;
            if (k == 6) fault_in = 1'b0;
        end
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        for (int k = 0; k <= 3; k++) begin
            @(negedge clk);
            if (k == 2) chk(!act_p(), "R10 restart from zero before A", int'(act_p()), 0);
            if (k == 3) chk(act_p() == 1'b1, "R10 restart primary at A", int'(act_p()), 1);
        end
        fault_halt = 1'b0;

        // R11: dropping run stops the timer
        stop_and_clear();
        start();
        for (int k = 0; k <= 15; k++) begin
            @(negedge clk);
            if (k == 7) run_en = 1'b0;
            if (k >= 8 && (act_p() || act_s() || strobe))
                chk(1'b0, "R11 rest after run low", {act_p(), act_s(), strobe}, 0);
            if (k == 15) chk(!pend && drv_p == pol_p, "R11 no pend after stop", {pend, drv_p}, int'(pol_p));
        end
        start();
        for (int k = 0; k <= 3; k++) begin
            @(negedge clk);
            if (k == 2) chk(!act_p(), "R11 counter cleared on restart", int'(act_p()), 0);
            if (k == 3) chk(act_p() == 1'b1, "R11 primary at A after restart", int'(act_p()), 1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule